// File: doc/BRIEF.md
# SPI Burst Host Engine

This block is a memory-mapped SPI host. Software reaches it through a simple 32-bit register port. It first sets the enable bit and the clock divider. It then loads a transmit word and writes one shift-control word. That single word starts a burst of 1 to 32 bits, picks the chip-select lines and says whether the chip select is released when the burst ends. The engine shifts the data out on MOSI, shifts the response in from MISO and stores the received word. It then clears the busy bit, which software polls.

Clearing the terminate flag keeps the chip select low after the burst. Several bursts can then form one long SPI transaction. A separate pin-level register sets the levels that chip select, SCK and MOSI take while no burst runs. Timing is SPI mode 0: MOSI changes as SCK falls, and MISO is sampled as SCK rises.

Top module: `spi_burst_host`

## Requirements
- R1: After reset the pin-level register reads 0x00070000, `cs_n` is 3'b111, `sck` and `mosi` are 0, and bit 31 of the shift-control register reads 0.
- R2: While bit 0 of the enable register (offset 0x00) is 0, a write to shift control starts nothing: busy stays 0 and SCK does not toggle.
- R3: With divider value d in bits 5:0 of offset 0x04, each SCK half period lasts d+1 system clock cycles, so consecutive SCK rises are 2*(d+1) cycles apart.
- R4: Shift control (offset 0x14) holds start/busy in bit 31, chip-select enables 0..2 in bits 28..30, the terminate flag in bit 26 and the bit count n in bits 5:0. An accepted start produces exactly n SCK pulses. A count of 0 or above 32 is ignored.
- R5: MOSI carries bits n-1 down to 0 of the data-out word (offset 0x10), most significant first. Data-out bits above n are never sent.
- R6: The n received bits land in data-in (offset 0x18) with the last bit at bit 0 and zeros above bit n-1.
- R7: Busy (bit 31 of shift control) is set when a start is accepted and clears by itself when the burst ends.
- R8: Every selected chip select is low while busy. With terminate 1 it returns to its idle level at the end of the burst. With terminate 0 it stays low until a later burst ends with terminate 1.
- R9: A write to shift control while busy is ignored: the running burst and the stored command are unchanged.
- R10: Data-in keeps its previous value throughout a burst and changes only when the burst completes.
- R11: The pin-level register (offset 0x08) sets the idle levels: bits 18:16 give chip selects 2..0, bit 8 gives SCK and bit 0 gives MOSI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| spi_sck | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | Host-to-device data |
| spi_miso | input | 1 | Device-to-host data |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
The hardest case to reach is a second shift-control write that arrives in the middle of a long, slow burst. Only then does it show whether the running burst, the stored command and the data-in word are all left alone. The stimulus starts a 32-bit burst at a wide divider setting. Partway through, it writes a conflicting command and reads back data-in and shift control. It then checks that the full 32 pulses still arrive with the original data. A terminate-0 burst followed by a terminate-1 burst on the same chip select shows that the select is held across bursts.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  // register byte offsets
  localparam logic [7:0] OFF_ENABLE = 8'h00;
  localparam logic [7:0] OFF_CLKDIV = 8'h04;
  localparam logic [7:0] OFF_PINS   = 8'h08;
  localparam logic [7:0] OFF_TXDATA = 8'h10;
  localparam logic [7:0] OFF_SHIFT  = 8'h14;
  localparam logic [7:0] OFF_RXDATA = 8'h18;

  // shift-control field positions
  localparam int SH_START_BIT = 31;
  localparam int SH_CS_LSB    = 28;
  localparam int SH_TERM_BIT  = 26;

  // pin-level register field positions
  localparam int PIN_CS_LSB   = 16;
  localparam int PIN_SCK_BIT  = 8;
  localparam int PIN_MOSI_BIT = 0;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_t;

endpackage

// File: rtl/spi_burst_regs.sv
module spi_burst_regs
  import spi_burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 6,
  parameter int NUM_CS = 3,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_word,
  output logic              en_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [NUM_CS-1:0] idle_cs_q,
  output logic              idle_sck_q,
  output logic              idle_mosi_q,
  output logic [DATA_W-1:0] tx_word_q,
  output logic [DATA_W-1:0] rx_word_q,
  output logic              start,
  output logic [NUM_CS-1:0] new_mask,
  output logic              new_term,
  output logic [CNT_W-1:0]  new_count,
  output logic [NUM_CS-1:0] cmd_mask_q,
  output logic              cmd_term_q,
  output logic [CNT_W-1:0]  cmd_count_q
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DATA_W);

  logic hit_shift;
  logic cnt_ok;
  logic [DATA_W-1:0] rd_mux;

  assign new_mask  = bus_wdata[SH_CS_LSB +: NUM_CS];
  assign new_term  = bus_wdata[SH_TERM_BIT];
  assign new_count = bus_wdata[CNT_W-1:0];
  assign cnt_ok    = (new_count != '0) && (new_count <= MAX_CNT);
  assign hit_shift = bus_we && (bus_addr == ADDR_W'(OFF_SHIFT));
  assign start     = hit_shift && bus_wdata[SH_START_BIT] && en_q && !busy && cnt_ok;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFF_ENABLE)) begin
      rd_mux[0] = en_q;
    end else if (bus_addr == ADDR_W'(OFF_CLKDIV)) begin
      rd_mux[DIV_W-1:0] = div_q;
    end else if (bus_addr == ADDR_W'(OFF_PINS)) begin
      rd_mux[PIN_CS_LSB +: NUM_CS] = idle_cs_q;
      rd_mux[PIN_SCK_BIT]          = idle_sck_q;
      rd_mux[PIN_MOSI_BIT]         = idle_mosi_q;
    end else if (bus_addr == ADDR_W'(OFF_TXDATA)) begin
      rd_mux = tx_word_q;
    end else if (bus_addr == ADDR_W'(OFF_SHIFT)) begin
      rd_mux[SH_START_BIT]          = busy;
      rd_mux[SH_CS_LSB +: NUM_CS]   = cmd_mask_q;
      rd_mux[SH_TERM_BIT]           = cmd_term_q;
      rd_mux[CNT_W-1:0]             = cmd_count_q;
    end else if (bus_addr == ADDR_W'(OFF_RXDATA)) begin
      rd_mux = rx_word_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= 1'b0;
      div_q       <= '0;
      idle_cs_q   <= '1;
      idle_sck_q  <= 1'b0;
      idle_mosi_q <= 1'b0;
      tx_word_q   <= '0;
      rx_word_q   <= '0;
      cmd_mask_q  <= '0;
      cmd_term_q  <= 1'b0;
      cmd_count_q <= '0;
      bus_rdata   <= '0;
    end else begin
      bus_rdata <= rd_mux;
      if (bus_we) begin
        if (bus_addr == ADDR_W'(OFF_ENABLE)) en_q <= bus_wdata[0];
        if (bus_addr == ADDR_W'(OFF_CLKDIV)) div_q <= bus_wdata[DIV_W-1:0];
        if (bus_addr == ADDR_W'(OFF_PINS)) begin
          idle_cs_q   <= bus_wdata[PIN_CS_LSB +: NUM_CS];
          idle_sck_q  <= bus_wdata[PIN_SCK_BIT];
          idle_mosi_q <= bus_wdata[PIN_MOSI_BIT];
        end
        if (bus_addr == ADDR_W'(OFF_TXDATA)) tx_word_q <= bus_wdata;
      end
      if (start) begin
        cmd_mask_q  <= new_mask;
        cmd_term_q  <= new_term;
        cmd_count_q <= new_count;
      end
      if (done) rx_word_q <= rx_word;
    end
  end

endmodule

// File: rtl/spi_burst_baud.sv
module spi_burst_baud #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
  import spi_burst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 6,
  parameter int NUM_CS = 3,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic [NUM_CS-1:0] idle_cs,
  input  logic              idle_sck,
  input  logic              idle_mosi,
  input  logic              start,
  input  logic [NUM_CS-1:0] new_mask,
  input  logic              new_term,
  input  logic [CNT_W-1:0]  new_count,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n
);

  localparam logic [CNT_W:0] FULL_W = (CNT_W+1)'(DATA_W);

  eng_state_t        state_q;
  logic [DATA_W-1:0] tx_sr_q;
  logic [DATA_W-1:0] rx_sr_q;
  logic [CNT_W-1:0]  left_q;
  logic              term_q;
  logic [NUM_CS-1:0] hold_q;
  logic [NUM_CS-1:0] hold_nxt;
  logic              tick;
  logic              last_fall;
  logic [CNT_W:0]    align_amt;
  logic [DATA_W-1:0] aligned;

  spi_burst_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (div),
    .tick (tick)
  );

  assign busy      = (state_q == ENG_RUN);
  assign last_fall = busy && tick && sck && (left_q == CNT_W'(1));
  assign done      = last_fall && en;
  assign rx_word   = rx_sr_q;
  assign align_amt = FULL_W - {1'b0, new_count};
  assign aligned   = tx_word << align_amt;

  always_comb begin
    hold_nxt = hold_q;
    if (!en) begin
      hold_nxt = '0;
    end else if (!busy && start) begin
      hold_nxt = new_mask;
    end else if (last_fall && term_q) begin
      hold_nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      left_q  <= '0;
      term_q  <= 1'b0;
      hold_q  <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= '1;
    end else begin
      hold_q <= hold_nxt;
      cs_n   <= idle_cs & ~hold_nxt;
      if (!en) begin
        state_q <= ENG_IDLE;
        sck     <= idle_sck;
        mosi    <= idle_mosi;
      end else begin
        case (state_q)
          ENG_IDLE: begin
            sck  <= idle_sck;
            mosi <= idle_mosi;
            if (start) begin
              state_q <= ENG_RUN;
              sck     <= 1'b0;
              tx_sr_q <= aligned;
              mosi    <= aligned[DATA_W-1];
              rx_sr_q <= '0;
              left_q  <= new_count;
              term_q  <= new_term;
            end
          end
          ENG_RUN: begin
            if (tick) begin
              if (!sck) begin
                sck     <= 1'b1;
                rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso};
              end else begin
                sck     <= 1'b0;
                tx_sr_q <= tx_sr_q << 1;
                mosi    <= tx_sr_q[DATA_W-2];
                left_q  <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                  state_q <= ENG_IDLE;
                  mosi    <= idle_mosi;
                end
              end
            end
          end
          default: state_q <= ENG_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_burst_host.sv
module spi_burst_host #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 6,
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              en_q;
  logic [DIV_W-1:0]  div_q;
  logic [NUM_CS-1:0] idle_cs_q;
  logic              idle_sck_q;
  logic              idle_mosi_q;
  logic [DATA_W-1:0] tx_word_q;
  logic [DATA_W-1:0] rx_word_q;
  logic              start;
  logic [NUM_CS-1:0] new_mask;
  logic              new_term;
  logic [CNT_W-1:0]  new_count;
  logic [NUM_CS-1:0] cmd_mask_q;
  logic              cmd_term_q;
  logic [CNT_W-1:0]  cmd_count_q;
  logic              busy;
  logic              done;
  logic [DATA_W-1:0] rx_word;

  spi_burst_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .NUM_CS(NUM_CS)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .busy        (busy),
    .done        (done),
    .rx_word     (rx_word),
    .en_q        (en_q),
    .div_q       (div_q),
    .idle_cs_q   (idle_cs_q),
    .idle_sck_q  (idle_sck_q),
    .idle_mosi_q (idle_mosi_q),
    .tx_word_q   (tx_word_q),
    .rx_word_q   (rx_word_q),
    .start       (start),
    .new_mask    (new_mask),
    .new_term    (new_term),
    .new_count   (new_count),
    .cmd_mask_q  (cmd_mask_q),
    .cmd_term_q  (cmd_term_q),
    .cmd_count_q (cmd_count_q)
  );

  spi_burst_shifter #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .NUM_CS(NUM_CS)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en        (en_q),
    .div       (div_q),
    .idle_cs   (idle_cs_q),
    .idle_sck  (idle_sck_q),
    .idle_mosi (idle_mosi_q),
    .start     (start),
    .new_mask  (new_mask),
    .new_term  (new_term),
    .new_count (new_count),
    .tx_word   (tx_word_q),
    .miso      (spi_miso),
    .busy      (busy),
    .done      (done),
    .rx_word   (rx_word),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .cs_n      (spi_cs_n)
  );

endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 3,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              en,
  input logic              busy,
  input logic              sck,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_n,
  input logic [NUM_CS-1:0] idle_cs,
  input logic [NUM_CS-1:0] cmd_mask,
  input logic              cmd_term,
  input logic [CNT_W-1:0]  cmd_count,
  input logic [DATA_W-1:0] rx_word
);

  logic           busy_d;
  logic           sck_d;
  logic [CNT_W:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_d   <= 1'b0;
      sck_d    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      busy_d <= busy;
      sck_d  <= sck;
      if (busy && !busy_d) rise_cnt <= '0;
      else if (busy && sck && !sck_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R4: pulse count equals programmed count
  assert_pulse_count_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_d && !busy && en) |-> (rise_cnt == {1'b0, cmd_count}));

  // R8: selected chip selects low while busy
  assert_cs_active_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((cs_n & cmd_mask) == '0));

  // R8: terminate releases chip select
  assert_cs_release_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_d && !busy && en && cmd_term) |-> ((cs_n & cmd_mask) == (idle_cs & cmd_mask)));

  // R5: MOSI moves only with a falling SCK inside a burst
  assert_mosi_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && busy_d && !(sck_d && !sck)) |-> (mosi == $past(mosi)));

  // R10: data-in frozen during a burst
  assert_rx_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && busy_d) |-> $stable(rx_word));

  // R9: shift-control write while busy leaves the command unchanged
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we && bus_addr == ADDR_W'(8'h14)) |=> ($stable(cmd_count) && $stable(cmd_mask)));

  // R2: no burst runs while disabled
  assert_idle_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(en)) |-> !busy);

endmodule

bind spi_burst_host spi_burst_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .en        (en_q),
  .busy      (busy),
  .sck       (spi_sck),
  .mosi      (spi_mosi),
  .cs_n      (spi_cs_n),
  .idle_cs   (idle_cs_q),
  .cmd_mask  (cmd_mask_q),
  .cmd_term  (cmd_term_q),
  .cmd_count (cmd_count_q),
  .rx_word   (rx_word_q)
);

// File: tb/spi_burst_host_bench.sv
module spi_burst_host_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck;
  logic        spi_mosi;
  logic        spi_miso;
  logic [2:0]  spi_cs_n;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // device model state
  int          rise_cnt = 0;
  int          fall_cnt = 0;
  int          fall_base = 0;
  int          cyc = 0;
  int          rise_t_last = 0;
  int          rise_t_prev = 0;
  logic [31:0] cap = '0;
  logic        sck_prev = 1'b0;
  int          cur_n = 0;
  logic [31:0] slv_pat = '0;

  always #4 clk = ~clk;

  spi_burst_host u_spi_burst_host (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always_comb begin
    int k;
    k = fall_cnt - fall_base;
    if (k >= 0 && k < cur_n) spi_miso = slv_pat[cur_n - 1 - k];
    else spi_miso = 1'b0;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    sck_prev <= spi_sck;
    if (!rst && spi_sck && !sck_prev) begin
      rise_cnt    <= rise_cnt + 1;
      cap         <= {cap[30:0], spi_mosi};
      rise_t_prev <= rise_t_last;
      rise_t_last <= cyc;
    end
    if (!rst && !spi_sck && sck_prev) fall_cnt <= fall_cnt + 1;
  end

  function automatic logic [31:0] low_mask(int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h14, v);
      if (!v[31]) return;
    end
  endtask

  function automatic logic [31:0] shift_word(int cs, bit term, int n);
    return 32'h8000_0000 | (32'd1 << (28 + cs)) | (32'(term) << 26) | 32'(n);
  endfunction

  task automatic test_reset();
    logic [31:0] v;
    rd(8'h08, v); chk("R1 pin reg", v, 32'h0007_0000);
    chk("R1 cs_n", {29'd0, spi_cs_n}, 32'd7);
    chk("R1 sck/mosi", {30'd0, spi_sck, spi_mosi}, 32'd0);
    rd(8'h14, v); chk("R1 busy", {31'd0, v[31]}, 32'd0);
  endtask

  task automatic test_disabled();
    logic [31:0] v;
    int r0;
    r0 = rise_cnt;
    wr(8'h14, shift_word(0, 1, 8));
    repeat (20) @(negedge clk);
    rd(8'h14, v); chk("R2 busy while disabled", {31'd0, v[31]}, 32'd0);
    chk("R2 no sck", 32'(rise_cnt - r0), 32'd0);
  endtask

  task automatic burst(int n, int d, int cs, bit term, logic [31:0] dout, logic [31:0] pat);
    logic [31:0] v;
    int r0;
    logic [2:0] exp_cs;
    wr(8'h04, 32'(d));
    wr(8'h10, dout);
    cur_n = n; slv_pat = pat; fall_base = fall_cnt; r0 = rise_cnt;
    wr(8'h14, shift_word(cs, term, n));
    rd(8'h14, v); chk("R7 busy set", {31'd0, v[31]}, 32'd1);
    wait_idle();
    rd(8'h14, v); chk("R7 busy cleared", {31'd0, v[31]}, 32'd0);
    chk("R4 pulse count", 32'(rise_cnt - r0), 32'(n));
    chk("R5 mosi data", cap & low_mask(n), dout & low_mask(n));
    rd(8'h18, v); chk("R6 data-in", v, pat & low_mask(n));
    if (n >= 2) chk("R3 sck period", 32'(rise_t_last - rise_t_prev), 32'(2 * (d + 1)));
    exp_cs = term ? 3'b111 : (3'b111 & ~(3'b001 << cs));
    chk("R8 cs after burst", {29'd0, spi_cs_n}, {29'd0, exp_cs});
  endtask

  task automatic test_busy_write();
    logic [31:0] v;
    logic [31:0] old;
    int r0;
    rd(8'h18, old);
    wr(8'h04, 32'd3);
    wr(8'h10, 32'h1357_9BDF);
    cur_n = 32; slv_pat = 32'hC3A5_0F96; fall_base = fall_cnt; r0 = rise_cnt;
    wr(8'h14, shift_word(2, 1, 32));
    repeat (30) @(negedge clk);
    chk("R8 cs low mid-burst", {29'd0, spi_cs_n}, 32'd3);
    wr(8'h14, shift_word(0, 0, 8));
    rd(8'h18, v); chk("R10 data-in held", v, old);
    rd(8'h14, v); chk("R9 command unchanged", v, 32'hC400_0020);
    wait_idle();
    chk("R9 pulse count", 32'(rise_cnt - r0), 32'd32);
    chk("R9 mosi data", cap, 32'h1357_9BDF);
    rd(8'h18, v); chk("R10 data-in updated", v, 32'hC3A5_0F96);
    chk("R8 cs released", {29'd0, spi_cs_n}, 32'd7);
  endtask

  task automatic test_bad_count();
    logic [31:0] v;
    int r0;
    r0 = rise_cnt;
    wr(8'h14, shift_word(0, 1, 0));
    repeat (10) @(negedge clk);
    rd(8'h14, v); chk("R4 count 0 ignored", {31'd0, v[31]}, 32'd0);
    wr(8'h14, shift_word(0, 1, 33));
    repeat (10) @(negedge clk);
    rd(8'h14, v); chk("R4 count 33 ignored", {31'd0, v[31]}, 32'd0);
    chk("R4 no pulses", 32'(rise_cnt - r0), 32'd0);
  endtask

  task automatic test_pins();
    wr(8'h08, 32'h0005_0101);
    @(negedge clk);
    chk("R11 cs idle", {29'd0, spi_cs_n}, 32'd5);
    chk("R11 sck/mosi idle", {30'd0, spi_sck, spi_mosi}, 32'd3);
    wr(8'h08, 32'h0007_0000);
    @(negedge clk);
    chk("R11 restore", {29'd0, spi_cs_n, spi_sck, spi_mosi}, 32'h1C);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_disabled();
    wr(8'h00, 32'd1);
    burst(8, 0, 0, 1, 32'hFFFF_FF5A, 32'h0000_003C);
    burst(16, 2, 2, 1, 32'h0000_1234, 32'h0000_BEEF);
    burst(24, 1, 0, 1, 32'h00C0_FFEE, 32'h005A_5A5A);
    burst(1, 63, 1, 1, 32'h0000_0001, 32'h0000_0001);
    burst(2, 63, 0, 1, 32'h0000_0002, 32'h0000_0001);
    burst(32, 5, 2, 1, 32'hDEAD_BEEF, 32'h8765_4321);
    burst(8, 1, 1, 0, 32'h0000_00A1, 32'h0000_0077);
    burst(8, 1, 1, 1, 32'h0000_00B2, 32'h0000_0088);
    test_busy_write();
    test_bad_count();
    test_pins();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule